// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits on the I/O side of an 8-bit processor bus with a 16-bit address. It watches I/O write cycles for two paging ports and keeps a small amount of configuration state. From that state it derives which bank is visible in each of the four 16 KB windows of the address space. It also derives the ROM bank number, the bank holding the display, and whether a given address falls in a bank that the video logic contends for. The memories themselves live elsewhere. They use the slot outputs to steer their chip selects and bank address bits.

The block has two mapping schemes. In the normal scheme, a ROM occupies the lowest window, the two middle windows hold fixed RAM banks, and the top window holds a RAM bank that software selects. The special scheme fills all four windows with RAM in one of four fixed orders. The primary port also has a lock bit. Once it is set, the whole configuration is frozen until reset. The secondary port carries two bits that do no paging: a disk-motor enable and a printer strobe. The block holds both bits and drives them out. A separate lookup input takes any 16-bit address and returns the bank, the ROM/RAM flag and the contention flag for that address.

All paging state changes on the clock edge that samples a qualifying write. The map outputs are combinational from that state, so they show the new map from the cycle after the write onwards.

Top module: `page_ctrl`

## Requirements
- R1: After reset, the map is as follows. Slot 0 is ROM bank 0 (`slot0_rom`=1, `slot_bank0`=0). Slot 1 is RAM bank 5, slot 2 is RAM bank 2 and slot 3 is RAM bank 0. `disp_bank`=5, `rom_bank`=0, `locked`=0, `motor_on`=0 and `prn_strobe_n`=0.
- R2: A primary-port write is a cycle with `io_req`=1 and `wr_en`=1 where addr[15]=0, addr[14]=1 and addr[1]=0. Such a write loads data[5:0] into the primary register, and the new value appears after the next rising clock edge. In the normal scheme, data[2:0] becomes the RAM bank of slot 3.
- R3: Primary bit 3 selects the display bank: 0 gives `disp_bank`=5 and 1 gives `disp_bank`=7.
- R4: In the normal scheme, slot 0 is ROM (`slot0_rom`=1 and `slot_bank0` equals the ROM bank number). Slot 1 is always bank 5 and slot 2 is always bank 2.
- R5: `rom_bank` equals {secondary bit 2, primary bit 4}, so four ROM banks can be selected.
- R6: Primary bit 5 is a lock. Once it is set, `locked`=1 and writes to either port change nothing until reset.
- R7: A secondary-port write is a cycle with `io_req`=1 and `wr_en`=1 where addr[15:12]=4'b0001 and addr[1]=0. Such a write loads data[4:0]. Bit 0 selects the special scheme and bits 2:1 select its order. The banks for slots 0..3 are 0,1,2,3 for order 00; 4,5,6,7 for 01; 4,5,6,3 for 10; and 4,7,6,3 for 11. In the special scheme `slot0_rom`=0.
- R8: `motor_on` follows secondary bit 3 and `prn_strobe_n` follows secondary bit 4.
- R9: The following cycles change no state: reads (`wr_en`=0), memory cycles (`io_req`=0), and I/O writes that match neither port decode.
- R10: `look_addr[15:14]` picks a slot. `look_bank` and `look_rom` give that slot's bank and ROM flag. `contended`=1 exactly when the slot holds RAM bank 4..7; ROM is never contended.
- R11: Reset clears the lock, and afterwards both ports accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Bus cycle is an I/O cycle |
| wr_en | input | 1 | Bus cycle is a write |
| addr | input | 16 | Bus address |
| data | input | 8 | Bus write data |
| look_addr | input | 16 | Address to translate for the lookup outputs |
| slot_bank0 | output | 3 | Bank in window 0000-3FFF (ROM number when ROM) |
| slot_bank1 | output | 3 | Bank in window 4000-7FFF |
| slot_bank2 | output | 3 | Bank in window 8000-BFFF |
| slot_bank3 | output | 3 | Bank in window C000-FFFF |
| slot0_rom | output | 1 | Window 0 holds ROM |
| rom_bank | output | 2 | Selected ROM bank |
| disp_bank | output | 3 | RAM bank holding the display |
| look_bank | output | 3 | Bank for look_addr |
| look_rom | output | 1 | look_addr falls in ROM |
| contended | output | 1 | look_addr falls in RAM bank 4..7 |
| motor_on | output | 1 | Disk motor enable |
| prn_strobe_n | output | 1 | Printer strobe, active low |
| locked | output | 1 | Configuration frozen |

## Verification
Two events can fall in the same cycle: a primary write that both sets the lock and changes the banks, and the configuration freeze that the lock causes. The bench sends one value that has the lock bit set together with a new slot-3 bank, display select and ROM bit. It checks that all of those fields take effect. Later writes to both ports must then leave every output unchanged. In a second clash, the lookup is read in the cycle right after a page write lands. It must already report the new bank and contention for the top window.

// File: rtl/page_pkg.sv
package page_pkg;
  localparam int BANK_W   = 3;
  localparam int SLOT_CNT = 4;
  localparam int SLOT_W   = $clog2(SLOT_CNT);
  localparam int ROM_W    = 2;

  typedef logic [BANK_W-1:0] bank_t;

  // primary register, bit 5 down to bit 0
  typedef struct packed {
    logic        lock;
    logic        rom_lo;
    logic        scr;
    logic [2:0]  ram;
  } prim_t;

  // secondary register, bit 4 down to bit 0
  typedef struct packed {
    logic        strobe_n;
    logic        motor;
    logic [1:0]  order;
    logic        special;
  } sec_t;
endpackage

// File: rtl/page_port_dec.sv
module page_port_dec #(
  parameter int ADDR_W = 16
) (
  input  logic              io_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_prim,
  output logic              hit_sec
);
  logic io_wr;
  logic unused_addr_bits;

  assign io_wr    = io_req & wr_en;
  assign hit_prim = io_wr & ~addr[ADDR_W-1] & addr[ADDR_W-2] & ~addr[1];
  assign hit_sec  = io_wr & (addr[ADDR_W-1 -: 4] == 4'b0001) & ~addr[1];
  assign unused_addr_bits = ^{addr[ADDR_W-5:2], addr[0]};
endmodule

// File: rtl/page_regs.sv
module page_regs
  import page_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_prim,
  input  logic              hit_sec,
  input  logic [DATA_W-1:0] data,
  output prim_t             prim_q,
  output sec_t              sec_q
);
  localparam int PRIM_W = $bits(prim_t);
  localparam int SEC_W  = $bits(sec_t);

  logic unused_data_bits;
  assign unused_data_bits = ^data[DATA_W-1:PRIM_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else if (!prim_q.lock) begin
      if (hit_prim) prim_q <= prim_t'(data[PRIM_W-1:0]);
      if (hit_sec)  sec_q  <= sec_t'(data[SEC_W-1:0]);
    end
  end

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q.lock |=> prim_q.lock);
  assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q.lock |=> ($stable(prim_q) && $stable(sec_q)));
  assert_prim_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_prim && !prim_q.lock) |=> (prim_q == $past(data[PRIM_W-1:0])));
  assert_sec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_sec && !prim_q.lock) |=> (sec_q == $past(data[SEC_W-1:0])));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_prim && !hit_sec) |=> ($stable(prim_q) && $stable(sec_q)));
endmodule

// File: rtl/page_map.sv
module page_map
  import page_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  prim_t                             prim,
  input  sec_t                              sec,
  input  logic [ADDR_W-1:0]                 look_addr,
  output logic [SLOT_CNT-1:0][BANK_W-1:0]   slot_bank,
  output logic                              slot0_rom,
  output logic [ROM_W-1:0]                  rom_bank,
  output logic [BANK_W-1:0]                 disp_bank,
  output logic [BANK_W-1:0]                 look_bank,
  output logic                              look_rom,
  output logic                              contended
);
  logic [SLOT_CNT-1:0] slot_cont;
  logic [SLOT_CNT-1:0] slot_rom;
  logic [SLOT_W-1:0]   look_slot;
  logic                unused_look_bits;

  assign rom_bank  = {sec.order[1], prim.rom_lo};
  assign disp_bank = prim.scr ? BANK_W'(7) : BANK_W'(5);

  always_comb begin
    slot0_rom = !sec.special;
    if (sec.special) begin
      unique case (sec.order)
        2'b00: slot_bank = {BANK_W'(3), BANK_W'(2), BANK_W'(1), BANK_W'(0)};
        2'b01: slot_bank = {BANK_W'(7), BANK_W'(6), BANK_W'(5), BANK_W'(4)};
        2'b10: slot_bank = {BANK_W'(3), BANK_W'(6), BANK_W'(5), BANK_W'(4)};
        default: slot_bank = {BANK_W'(3), BANK_W'(6), BANK_W'(7), BANK_W'(4)};
      endcase
    end else begin
      slot_bank = {BANK_W'(prim.ram), BANK_W'(2), BANK_W'(5),
                   BANK_W'(rom_bank)};
    end
  end

  generate
    for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
      if (i == 0) begin : g_rom_slot
        assign slot_rom[i] = slot0_rom;
      end else begin : g_ram_slot
        assign slot_rom[i] = 1'b0;
      end
      assign slot_cont[i] = !slot_rom[i] && slot_bank[i][BANK_W-1];
    end
  endgenerate

  assign look_slot = look_addr[ADDR_W-1 -: SLOT_W];
  assign look_bank = slot_bank[look_slot];
  assign look_rom  = slot_rom[look_slot];
  assign contended = slot_cont[look_slot];
  assign unused_look_bits = ^look_addr[ADDR_W-SLOT_W-1:0];
endmodule

// File: rtl/page_ctrl.sv
module page_ctrl
  import page_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [2:0]        slot_bank0,
  output logic [2:0]        slot_bank1,
  output logic [2:0]        slot_bank2,
  output logic [2:0]        slot_bank3,
  output logic              slot0_rom,
  output logic [1:0]        rom_bank,
  output logic [2:0]        disp_bank,
  output logic [2:0]        look_bank,
  output logic              look_rom,
  output logic              contended,
  output logic              motor_on,
  output logic              prn_strobe_n,
  output logic              locked
);
  logic  hit_prim, hit_sec;
  prim_t prim_q;
  sec_t  sec_q;
  logic [SLOT_CNT-1:0][BANK_W-1:0] slot_bank;

  page_port_dec #(.ADDR_W(ADDR_W)) u_dec (
    .io_req(io_req), .wr_en(wr_en), .addr(addr),
    .hit_prim(hit_prim), .hit_sec(hit_sec)
  );

  page_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hit_prim(hit_prim), .hit_sec(hit_sec),
    .data(data), .prim_q(prim_q), .sec_q(sec_q)
  );

  page_map #(.ADDR_W(ADDR_W)) u_map (
    .prim(prim_q), .sec(sec_q), .look_addr(look_addr),
    .slot_bank(slot_bank), .slot0_rom(slot0_rom), .rom_bank(rom_bank),
    .disp_bank(disp_bank), .look_bank(look_bank), .look_rom(look_rom),
    .contended(contended)
  );

  assign slot_bank0   = slot_bank[0];
  assign slot_bank1   = slot_bank[1];
  assign slot_bank2   = slot_bank[2];
  assign slot_bank3   = slot_bank[3];
  assign motor_on     = sec_q.motor;
  assign prn_strobe_n = sec_q.strobe_n;
  assign locked       = prim_q.lock;

  assert_special_no_rom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.special |-> !slot0_rom);
  assert_special_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.special |-> (slot_bank0 != slot_bank1 && slot_bank0 != slot_bank2 &&
                       slot_bank0 != slot_bank3 && slot_bank1 != slot_bank2 &&
                       slot_bank1 != slot_bank3 && slot_bank2 != slot_bank3));
  assert_normal_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_q.special |-> (slot0_rom && slot_bank1 == 3'd5 && slot_bank2 == 3'd2));
  assert_rom_never_contended_R10: assert property (@(posedge clk) disable iff (!rst_n)
    look_rom |-> !contended);
  assert_display_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bank == 3'd5) || (disp_bank == 3'd7));
endmodule

// File: tb/sim_page_ctrl.sv
module sim_page_ctrl;
  localparam time HALF = 2ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [15:0] look_addr = '0;
  logic [2:0]  slot_bank0, slot_bank1, slot_bank2, slot_bank3;
  logic        slot0_rom;
  logic [1:0]  rom_bank;
  logic [2:0]  disp_bank, look_bank;
  logic        look_rom, contended, motor_on, prn_strobe_n, locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0] e_p = '0;
  logic [4:0] e_s = '0;

  always #HALF clk = ~clk;

  page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .wr_en(wr_en), .addr(addr),
    .data(data), .look_addr(look_addr), .slot_bank0(slot_bank0),
    .slot_bank1(slot_bank1), .slot_bank2(slot_bank2), .slot_bank3(slot_bank3),
    .slot0_rom(slot0_rom), .rom_bank(rom_bank), .disp_bank(disp_bank),
    .look_bank(look_bank), .look_rom(look_rom), .contended(contended),
    .motor_on(motor_on), .prn_strobe_n(prn_strobe_n), .locked(locked)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bank(input int i);
    int ord = int'(e_s[2:1]);
    if (!e_s[0]) begin
      case (i)
        0: return int'({e_s[2], e_p[4]});
        1: return 5;
        2: return 2;
        default: return int'(e_p[2:0]);
      endcase
    end
    if (ord == 0) return i;
    case (i)
      0: return 4;
      1: return (ord == 3) ? 7 : 5;
      2: return 6;
      default: return (ord == 1) ? 7 : 3;
    endcase
  endfunction

  function automatic int act_bank(input int i);
    case (i)
      0: return int'(slot_bank0);
      1: return int'(slot_bank1);
      2: return int'(slot_bank2);
      default: return int'(slot_bank3);
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " R4 R7 slot"}, $sformatf("slot%0d", i), act_bank(i), exp_bank(i));
    end
    chk({tag, " R4 R7"}, "slot0_rom", int'(slot0_rom), int'(!e_s[0]));
    chk({tag, " R5"}, "rom_bank", int'(rom_bank), int'({e_s[2], e_p[4]}));
    chk({tag, " R3"}, "disp_bank", int'(disp_bank), e_p[3] ? 7 : 5);
    chk({tag, " R8"}, "motor_on", int'(motor_on), int'(e_s[3]));
    chk({tag, " R8"}, "prn_strobe_n", int'(prn_strobe_n), int'(e_s[4]));
    chk({tag, " R6"}, "locked", int'(locked), int'(e_p[5]));
    for (int i = 0; i < 4; i++) begin
      int eb = exp_bank(i);
      bit er = (i == 0) && !e_s[0];
      look_addr = 16'((i << 14) | ((i * 16'h0A5B) & 16'h3FFF));
      #0.1ns;
      chk({tag, " R10"}, $sformatf("look_bank s%0d", i), int'(look_bank), eb);
      chk({tag, " R10"}, $sformatf("look_rom s%0d", i), int'(look_rom), int'(er));
      chk({tag, " R10"}, $sformatf("contended s%0d", i), int'(contended),
          int'(!er && eb >= 4));
    end
  endtask

  task automatic bus_cycle(input logic rq, input logic wr, input logic [15:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    io_req = rq; wr_en = wr; addr = a; data = d;
    @(negedge clk);
    io_req = 1'b0; wr_en = 1'b0; addr = '0; data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    e_p = '0; e_s = '0;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_all("R1 reset");

    // full sweep of secondary x unlocked primary values
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 32; p++) begin
        bus_cycle(1'b1, 1'b1, 16'h1FFD, 8'(s)); e_s = 5'(s);
        bus_cycle(1'b1, 1'b1, 16'h7FFD, 8'(p)); e_p = 6'(p);
        check_all("R2 R7 sweep");
      end
    end

    // alias decodes: minimal address bits only
    bus_cycle(1'b1, 1'b1, 16'h1000, 8'h00); e_s = 5'h00;
    bus_cycle(1'b1, 1'b1, 16'h4000, 8'hC6); e_p = 6'h06;
    check_all("R2 R7 alias");

    // R9: cycles that must change nothing
    bus_cycle(1'b0, 1'b1, 16'h7FFD, 8'h01);
    bus_cycle(1'b1, 1'b0, 16'h7FFD, 8'h01);
    bus_cycle(1'b1, 1'b1, 16'hFFFD, 8'h01);
    bus_cycle(1'b1, 1'b1, 16'h7FFF, 8'h01);
    bus_cycle(1'b1, 1'b1, 16'h3FFD, 8'h01);
    bus_cycle(1'b1, 1'b1, 16'h1FFF, 8'h1F);
    bus_cycle(1'b0, 1'b1, 16'h1FFD, 8'h1F);
    check_all("R9 ignored");

    // lookup straight after a page write lands
    bus_cycle(1'b1, 1'b1, 16'h7FFD, 8'h04); e_p = 6'h04;
    look_addr = 16'hC123;
    #0.1ns;
    chk("R10 post-write", "look_bank", int'(look_bank), 4);
    chk("R10 post-write", "contended", int'(contended), 1);

    // lock together with new fields in one write
    bus_cycle(1'b1, 1'b1, 16'h1FFD, 8'h0C); e_s = 5'h0C;
    bus_cycle(1'b1, 1'b1, 16'h7FFD, 8'h3B); e_p = 6'h3B;
    check_all("R6 lock write");
    bus_cycle(1'b1, 1'b1, 16'h7FFD, 8'h00);
    bus_cycle(1'b1, 1'b1, 16'h1FFD, 8'h17);
    bus_cycle(1'b1, 1'b1, 16'h4000, 8'h07);
    check_all("R6 frozen");

    // R11: reset unlocks, ports accept writes again
    do_reset();
    check_all("R11 R1 after reset");
    bus_cycle(1'b1, 1'b1, 16'h1FFD, 8'h07); e_s = 5'h07;
    bus_cycle(1'b1, 1'b1, 16'h7FFD, 8'h0D); e_p = 6'h0D;
    check_all("R11 rewrite");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule